// File: doc/BRIEF.md
# Constant Off-Time Peak-Current PWM Controller

This block drives a single switch gate. It uses peak-current control with a fixed off time, and there is no switching clock. A pulse begins as soon as the off-time timer runs out. It ends for one of four reasons:

- the current-limit comparator trips after its blanking window;
- the overcurrent comparator trips after its own shorter blanking window;
- a hard maximum on-time cut-off is reached;
- the enable drops. The enable is the dimming input ANDed with a run enable from supervision logic.

The off-time timer starts from the cycle in which each on time ends. It holds the drive low for the programmed off time. While the enable is low, no new pulse is started.

Every on time produces exactly one end-cause strobe. A fault counter outside the block can therefore count one event per switching cycle. All durations are counted in system-clock cycles. The comparator inputs are digital, already synchronous to `clk`, and high while the sensed current is above the threshold.

Top module: `cot_pwm_ctrl`

## Requirements
- R1: While `rst_n` is low, `gate_drv` and all four strobes are low. Asserting reset forces them low at once.
- R2: With the enable high, the drive rises after exactly `max(toff_cycles, TOFF_MIN_CYC)` low cycles following each on-time end. After reset is released, the first pulse starts after `TOFF_MIN_CYC` low cycles.
- R3: An off-time request below `TOFF_MIN_CYC`, including zero, is clamped to `TOFF_MIN_CYC` cycles.
- R4: `ilim_trip` is ignored during the first `LEB_CYC` high cycles of a pulse. If it is held high from the start, the pulse lasts `LEB_CYC+1` cycles, which is the minimum on time.
- R5: If `ilim_trip` is high in high cycle n (counting from 0, with n ≥ `LEB_CYC`), the pulse is n+1 cycles wide and ends with `end_normal`.
- R6: `ocp_trip` is ignored only during the first `OCP_LEB_CYC` high cycles, where `OCP_LEB_CYC` < `LEB_CYC`. After that it ends the pulse in the same way, with `end_ocp`.
- R7: With no trip and the enable high, the pulse lasts exactly `MAXON_CYC` cycles and ends with `end_maxon`. No pulse is ever longer.
- R8: The enable is `dim_en & run_en`. If it is low in a high cycle, the pulse ends next cycle with `end_dim`, even inside a blanking window. While it stays low, the drive stays low. Once it rises again after the off time has elapsed, the drive rises on the next cycle.
- R9: Exactly one strobe pulses per on time. It lasts one cycle and coincides with the first low cycle of the drive. No strobe appears at any other time.
- R10: When several end causes occur in the same cycle, the strobe is chosen in this priority order: overcurrent, then current limit, then maximum on time, then enable loss.
- R11: The off time is captured when an on time ends. Changing `toff_cycles` during the off time does not alter the off time in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Run permission from supervision logic |
| dim_en | input | 1 | PWM dimming input; high allows switching |
| ilim_trip | input | 1 | Current-limit comparator output, synchronous |
| ocp_trip | input | 1 | Overcurrent comparator output, synchronous |
| toff_cycles | input | TOFF_W | Requested off time in clock cycles |
| gate_drv | output | 1 | Gate drive request |
| end_normal | output | 1 | On time ended by the current limit |
| end_ocp | output | 1 | On time ended by the overcurrent limit |
| end_maxon | output | 1 | On time ended by the maximum on-time cut-off |
| end_dim | output | 1 | On time ended by loss of enable |

## Verification
The bench measures the width, end cause and following off time of each pulse for trips that arrive:

- inside a blanking window, where a design that blanks wrongly shortens the pulse to a single cycle;
- exactly when a window opens, which exposes off-by-one errors in the window length;
- in the same cycle as another cause, where a wrong priority reports the wrong strobe or two strobes at once.

A trip that pulses only inside the long window must still yield a full maximum-length pulse. A design that latched the trip would cut that pulse short.

The off-time request is changed right after each on time ends. A design that does not capture it shows a different off time. Zero and tiny requests must come out at the clamped minimum.

The enable tests check three things: that a pulse is cut inside the blanking window, that the drive stays low while the enable is held off, and that the drive restarts on the very next cycle once the enable returns.

// File: rtl/cot_pkg.sv
package cot_pkg;
  // Bit position of each cause inside the strobe vector
  typedef enum logic [1:0] {
    CAUSE_NORMAL = 2'd0,
    CAUSE_OCP    = 2'd1,
    CAUSE_MAXON  = 2'd2,
    CAUSE_DIM    = 2'd3
  } end_cause_e;

  localparam int unsigned NUM_CAUSES = 4;
endpackage

// File: rtl/cot_on_timer.sv
// Counts drive-high cycles; opens the blanking windows and flags max on time.
module cot_on_timer #(
  parameter int unsigned LEB_CYC     = 68,
  parameter int unsigned OCP_LEB_CYC = 27,
  parameter int unsigned MAXON_CYC   = 4250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic drv,
  output logic ilim_open,
  output logic ocp_open,
  output logic maxon_hit
);
  localparam int unsigned CW = $clog2(MAXON_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;
  logic [1:0]    win_open;

  always_comb begin
    cnt_en = start | drv;
    cnt_d  = start ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // Window 0 gates the current limit, window 1 the overcurrent limit
  for (genvar g = 0; g < 2; g++) begin : g_win
    localparam int unsigned THR = (g == 0) ? LEB_CYC : OCP_LEB_CYC;
    assign win_open[g] = drv && (cnt_q >= CW'(THR));
  end

  assign ilim_open = win_open[0];
  assign ocp_open  = win_open[1];
  assign maxon_hit = drv && (cnt_q == CW'(MAXON_CYC - 1));
endmodule

// File: rtl/cot_off_timer.sv
// Holds the drive low for a captured, clamped off time.
module cot_off_timer #(
  parameter int unsigned TOFF_W       = 11,
  parameter int unsigned TOFF_MIN_CYC = 62
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              drv,
  input  logic              capture,
  input  logic [TOFF_W-1:0] toff_cycles,
  output logic              off_done
);
  logic [TOFF_W-1:0] len_q, len_d;
  logic [TOFF_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;

  always_comb begin
    len_d  = (toff_cycles < TOFF_W'(TOFF_MIN_CYC)) ? TOFF_W'(TOFF_MIN_CYC) : toff_cycles;
    off_done = !drv && (cnt_q == len_q - 1'b1);
    cnt_en = drv | !off_done;
    cnt_d  = drv ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       len_q <= TOFF_W'(TOFF_MIN_CYC);
    else if (capture) len_q <= len_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cot_end_arbiter.sv
// Picks the single cause that ends the on time and registers its strobe.
module cot_end_arbiter
  import cot_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  drv,
  input  logic                  enable,
  input  logic                  ilim_trip,
  input  logic                  ilim_open,
  input  logic                  ocp_trip,
  input  logic                  ocp_open,
  input  logic                  maxon_hit,
  output logic                  end_now,
  output logic [NUM_CAUSES-1:0] strobes
);
  end_cause_e                cause;
  logic [NUM_CAUSES-1:0]     strb_d;
  logic                      strb_en;

  always_comb begin
    end_now = 1'b1;
    cause   = CAUSE_DIM;
    if (!drv)                       end_now = 1'b0;
    else if (ocp_trip && ocp_open)  cause = CAUSE_OCP;
    else if (ilim_trip && ilim_open) cause = CAUSE_NORMAL;
    else if (maxon_hit)             cause = CAUSE_MAXON;
    else if (!enable)               cause = CAUSE_DIM;
    else                            end_now = 1'b0;
    strb_d  = end_now ? (NUM_CAUSES'(1) << cause) : '0;
    strb_en = end_now | (|strobes);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       strobes <= '0;
    else if (strb_en) strobes <= strb_d;
  end
endmodule

// File: rtl/cot_pwm_ctrl.sv
module cot_pwm_ctrl
  import cot_pkg::*;
#(
  parameter int unsigned LEB_CYC      = 68,
  parameter int unsigned OCP_LEB_CYC  = 27,
  parameter int unsigned MAXON_CYC    = 4250,
  parameter int unsigned TOFF_MIN_CYC = 62,
  parameter int unsigned TOFF_W       = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              dim_en,
  input  logic              ilim_trip,
  input  logic              ocp_trip,
  input  logic [TOFF_W-1:0] toff_cycles,
  output logic              gate_drv,
  output logic              end_normal,
  output logic              end_ocp,
  output logic              end_maxon,
  output logic              end_dim
);
  logic                  gate_q, gate_d, gate_en;
  logic                  enable, rise, end_now, off_done;
  logic                  ilim_open, ocp_open, maxon_hit;
  logic [NUM_CAUSES-1:0] strobes;

  always_comb begin
    enable  = run_en & dim_en;
    rise    = !gate_q && off_done && enable;
    gate_en = rise | end_now;
    gate_d  = rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gate_q <= 1'b0;
    else if (gate_en) gate_q <= gate_d;
  end

  cot_on_timer #(
    .LEB_CYC(LEB_CYC), .OCP_LEB_CYC(OCP_LEB_CYC), .MAXON_CYC(MAXON_CYC)
  ) u_on (
    .clk(clk), .rst_n(rst_n), .start(rise), .drv(gate_q),
    .ilim_open(ilim_open), .ocp_open(ocp_open), .maxon_hit(maxon_hit)
  );

  cot_off_timer #(
    .TOFF_W(TOFF_W), .TOFF_MIN_CYC(TOFF_MIN_CYC)
  ) u_off (
    .clk(clk), .rst_n(rst_n), .drv(gate_q), .capture(end_now),
    .toff_cycles(toff_cycles), .off_done(off_done)
  );

  cot_end_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .drv(gate_q), .enable(enable),
    .ilim_trip(ilim_trip), .ilim_open(ilim_open),
    .ocp_trip(ocp_trip), .ocp_open(ocp_open), .maxon_hit(maxon_hit),
    .end_now(end_now), .strobes(strobes)
  );

  assign gate_drv   = gate_q;
  assign end_normal = strobes[CAUSE_NORMAL];
  assign end_ocp    = strobes[CAUSE_OCP];
  assign end_maxon  = strobes[CAUSE_MAXON];
  assign end_dim    = strobes[CAUSE_DIM];
endmodule

// File: rtl/cot_pwm_ctrl_chk.sv
module cot_pwm_ctrl_chk #(
  parameter int unsigned LEB_CYC      = 68,
  parameter int unsigned OCP_LEB_CYC  = 27,
  parameter int unsigned MAXON_CYC    = 4250,
  parameter int unsigned TOFF_MIN_CYC = 62
) (
  input logic clk,
  input logic rst_n,
  input logic run_en,
  input logic dim_en,
  input logic gate_drv,
  input logic end_normal,
  input logic end_ocp,
  input logic end_maxon,
  input logic end_dim
);
  logic [31:0] hi_len, lo_len;
  logic        any_strb;

  assign any_strb = end_normal | end_ocp | end_maxon | end_dim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_len <= '0;
      lo_len <= '0;
    end else begin
      if (!gate_drv)          hi_len <= '0;
      else if (hi_len != '1)  hi_len <= hi_len + 1'b1;
      if (gate_drv)           lo_len <= '0;
      else if (lo_len != '1)  lo_len <= lo_len + 1'b1;
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({end_normal, end_ocp, end_maxon, end_dim})); // R9
  AST_STROBE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_drv) |-> any_strb); // R9
  AST_STROBE_ONLY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    any_strb |-> (!gate_drv && $past(gate_drv))); // R9
  AST_DISABLE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_drv && !(run_en && dim_en)) |=> !gate_drv); // R8
  AST_DISABLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_drv && !(run_en && dim_en)) |=> !gate_drv); // R8
  AST_MIN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_drv) |-> (lo_len >= TOFF_MIN_CYC)); // R3
  AST_MAXON_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    gate_drv |-> (hi_len < MAXON_CYC)); // R7
  AST_MAXON_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    end_maxon |-> (hi_len == MAXON_CYC)); // R7
  AST_ILIM_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    end_normal |-> (hi_len >= LEB_CYC + 1)); // R4
  AST_OCP_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    end_ocp |-> (hi_len >= OCP_LEB_CYC + 1)); // R6
endmodule

bind cot_pwm_ctrl cot_pwm_ctrl_chk #(
  .LEB_CYC(LEB_CYC), .OCP_LEB_CYC(OCP_LEB_CYC),
  .MAXON_CYC(MAXON_CYC), .TOFF_MIN_CYC(TOFF_MIN_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .dim_en(dim_en),
  .gate_drv(gate_drv), .end_normal(end_normal), .end_ocp(end_ocp),
  .end_maxon(end_maxon), .end_dim(end_dim)
);

// File: tb/cot_pwm_ctrl_bench.sv
module cot_pwm_ctrl_bench;
  localparam int LEB = 8, OLEB = 3, MAXON = 40, TMIN = 4, TW = 8;
  localparam int NV  = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0, run_en = 1'b0, dim_en = 1'b0;
  logic ilim_trip = 1'b0, ocp_trip = 1'b0;
  logic [TW-1:0] toff_cycles = '0;
  logic gate_drv, end_normal, end_ocp, end_maxon, end_dim;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #4 clk = ~clk;

  cot_pwm_ctrl #(
    .LEB_CYC(LEB), .OCP_LEB_CYC(OLEB), .MAXON_CYC(MAXON),
    .TOFF_MIN_CYC(TMIN), .TOFF_W(TW)
  ) u_cot_pwm_ctrl (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .dim_en(dim_en),
    .ilim_trip(ilim_trip), .ocp_trip(ocp_trip), .toff_cycles(toff_cycles),
    .gate_drv(gate_drv), .end_normal(end_normal), .end_ocp(end_ocp),
    .end_maxon(end_maxon), .end_dim(end_dim)
  );

  // toff, toff after end, ilim from, ilim until, ocp from, dim low from,
  // expected width, expected cause (0 normal,1 ocp,2 maxon,3 dim), expected off
  typedef struct packed {
    logic [7:0] toff, toff_after, ilim_at, ilim_to, ocp_at, dim_at, width, cause, off;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{8'd10,  8'd1,  8'd0,   8'd255, 8'd255, 8'd255, 8'd9,  8'd0, 8'd10 },
    '{8'd0,   8'd50, 8'd15,  8'd255, 8'd255, 8'd255, 8'd16, 8'd0, 8'd4  },
    '{8'd2,   8'd30, 8'd255, 8'd255, 8'd0,   8'd255, 8'd4,  8'd1, 8'd4  },
    '{8'd6,   8'd1,  8'd0,   8'd255, 8'd2,   8'd255, 8'd4,  8'd1, 8'd6  },
    '{8'd7,   8'd1,  8'd255, 8'd255, 8'd255, 8'd255, 8'd40, 8'd2, 8'd7  },
    '{8'd5,   8'd9,  8'd255, 8'd255, 8'd255, 8'd5,   8'd6,  8'd3, 8'd5  },
    '{8'd5,   8'd1,  8'd20,  8'd255, 8'd20,  8'd255, 8'd21, 8'd1, 8'd5  },
    '{8'd9,   8'd2,  8'd39,  8'd255, 8'd255, 8'd255, 8'd40, 8'd0, 8'd9  },
    '{8'd4,   8'd20, 8'd255, 8'd255, 8'd255, 8'd39,  8'd40, 8'd2, 8'd4  },
    '{8'd12,  8'd1,  8'd10,  8'd255, 8'd255, 8'd10,  8'd11, 8'd0, 8'd12 },
    '{8'd3,   8'd1,  8'd255, 8'd255, 8'd2,   8'd2,   8'd3,  8'd3, 8'd4  },
    '{8'd200, 8'd1,  8'd0,   8'd255, 8'd255, 8'd0,   8'd1,  8'd3, 8'd200},
    '{8'd6,   8'd1,  8'd2,   8'd7,   8'd255, 8'd255, 8'd40, 8'd2, 8'd6  }
  };

  localparam string VREQ [NV] = '{
    "R4", "R3/R5", "R3/R6", "R6/R10", "R7", "R8", "R10",
    "R10", "R10", "R10", "R8/R3", "R8", "R4/R7"
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // 0..3 = single cause, 4 = no strobe, 5 = several
  function automatic int cause_of();
    case ({end_dim, end_maxon, end_ocp, end_normal})
      4'b0001: return 0;
      4'b0010: return 1;
      4'b0100: return 2;
      4'b1000: return 3;
      4'b0000: return 4;
      default: return 5;
    endcase
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    int w;
    int off;
    int bad_hold;
    vec_t cv;

    // R1: reset state
    run_en = 1'b1;
    dim_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 drive in reset", int'(gate_drv), 0);
    check("R1 strobes in reset", cause_of(), 4);

    // R2: first pulse after reset waits the minimum off time
    rst_n = 1'b1;
    off = 0;
    while (!gate_drv) begin
      off++;
      @(negedge clk);
    end
    check("R2 first off time", off, TMIN);

    // Vector table: width, cause and following off time of each pulse (R11 on off)
    for (int v = 0; v < NV; v++) begin
      cv = VEC[v];
      w = 0;
      off = 0;
      toff_cycles = cv.toff;
      while (!gate_drv) @(negedge clk);
      while (gate_drv) begin
        ilim_trip = (w >= int'(cv.ilim_at)) && (w < int'(cv.ilim_to));
        ocp_trip  = (w >= int'(cv.ocp_at));
        dim_en    = !(w >= int'(cv.dim_at));
        w++;
        @(negedge clk);
      end
      check($sformatf("%s width v%0d", VREQ[v], v), w, int'(cv.width));
      check($sformatf("R9/%s cause v%0d", VREQ[v], v), cause_of(), int'(cv.cause));
      ilim_trip   = 1'b0;
      ocp_trip    = 1'b0;
      dim_en      = 1'b1;
      toff_cycles = cv.toff_after;
      while (!gate_drv) begin
        off++;
        @(negedge clk);
      end
      check($sformatf("R2/R11 off time v%0d", v), off, int'(cv.off));
    end

    // R8: run enable cut in first high cycle, hold, then resume
    run_en = 1'b0;
    @(negedge clk);
    check("R8 run off drive", int'(gate_drv), 0);
    check("R8 run off cause", cause_of(), 3);
    bad_hold = 0;
    repeat (20) begin
      @(negedge clk);
      if (gate_drv || cause_of() != 4) bad_hold++;
    end
    check("R8 hold low while disabled", bad_hold, 0);
    run_en = 1'b1;
    @(negedge clk);
    check("R8 resume next cycle", int'(gate_drv), 1);

    // R1: asynchronous reset during a pulse
    rst_n = 1'b0;
    #1;
    check("R1 async reset drive", int'(gate_drv), 0);
    check("R1 async reset strobes", cause_of(), 4);
    @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule